// File: doc/BRIEF.md
# Multi-Mode Real-Time Counter

This block keeps time from a slow oscillator clock. A power-of-two divider turns the clock into a count tick, and that tick drives a single 32-bit state register. The register is read in one of three ways. It can be a free-running 32-bit count with a compare match. It can be a 16-bit count that wraps at a programmable period. It can also be a packed calendar of seconds, minutes, hours, day, month and a 6-bit year offset, with a maskable alarm.

Software-side logic sets the mode, the divider exponent and the compare, period and alarm values on plain input ports. It can preset the state through a load port. The load is held until the next count tick and only then applied. The three event outputs each go high for one clock, in the cycle where the new count value appears. Changing the mode clears the state and all events.

Top module: `rtc_multimode`

## Requirements
- R1: With `en_i` high and divider exponent p = `presc_i` (values above 10 act as 10), the state advances once every 2^p clocks. Reset and `en_i` low clear the divider, and the first advance comes on the 2^p-th clock edge after enabling. While `en_i` is low, `count_o` holds.
- R2: In mode 0 (`mode_i` = 0), each tick adds one to the full 32-bit value, and 0xFFFFFFFF is followed by 0.
- R3: In mode 0, a tick taken while the count equals `cmp_val_i` raises `cmp_evt_o` for one clock. The next value is 0 if `clr_on_match_i` is high, and count+1 otherwise.
- R4: In mode 1, a tick at count == `period_i` (or at 0xFFFF) wraps the count to 0 and raises `ovf_evt_o`. Otherwise the count adds one. Bits 31:16 of `count_o` are always zero in this mode, and loaded values keep only their low 16 bits.
- R5: In mode 2, `count_o` packs year[31:26], month[25:22], day[21:17], hour[16:12], minute[11:6] and second[5:0]. Each tick adds one second, with carries through 60 s, 60 min, 24 h, the length of the month, 12 months and a year offset that wraps from 63 to 0.
- R6: February has 29 days when the year offset is divisible by four and 28 days otherwise. April, June, September and November have 30 days, and all other months have 31.
- R7: In mode 2, `alarm_evt_o` goes high for one clock when the new calendar value matches `alarm_i` in every field enabled by `alarm_en_i`. The enable bits map 0 to second, 1 to minute, 2 to hour, 3 to day, 4 to month and 5 to year. A tick that applies a load raises no event.
- R8: A pulse on `load_i` captures `load_val_i`. The captured value replaces the state on the first tick at or after the capture edge, and no increment happens on that tick.
- R9: When `mode_i` differs from the current mode, the next edge adopts the new mode. It also clears all events and any pending load, and sets the state to 0, or to year 0, 1 January, 00:00:00 (0x00420000) in mode 2.
- R10: The three events are mutually exclusive and only follow a tick. In mode 3 the state holds and loads are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| mode_i | input | 2 | 0: 32-bit count, 1: 16-bit period count, 2: calendar, 3: hold |
| presc_i | input | 4 | Divider exponent p (clock / 2^p) |
| cmp_val_i | input | 32 | Mode 0 compare value |
| clr_on_match_i | input | 1 | Mode 0 clear on compare match |
| period_i | input | 16 | Mode 1 wrap value |
| alarm_i | input | 32 | Mode 2 alarm, packed like the calendar |
| alarm_en_i | input | 6 | Per-field alarm enable |
| load_i | input | 1 | Load strobe |
| load_val_i | input | 32 | Value to load |
| count_o | output | 32 | Counter or packed calendar |
| cmp_evt_o | output | 1 | Compare match event |
| ovf_evt_o | output | 1 | Period wrap event |
| alarm_evt_o | output | 1 | Alarm event |

## Verification
The assertions check the properties that must hold every cycle. Events never overlap and only follow a tick. The state is stable between ticks. The upper half stays clear in 16-bit mode. A legal calendar value steps only to another legal one, and a mode change clears the events. The scenarios are needed for everything that depends on actual values. That covers the divide ratio for every exponent, the exact compare and period sequences, and month lengths and leap years across all months. It also covers the alarm field masking and when a deferred load lands.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int CNT_W = 32;

  typedef enum logic [1:0] {
    MODE_CNT32 = 2'd0,
    MODE_CNT16 = 2'd1,
    MODE_CAL   = 2'd2,
    MODE_HOLD  = 2'd3
  } rtc_mode_e;

  typedef struct packed {
    logic [5:0] year;
    logic [3:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  localparam cal_t CAL_RESET = '{year: 6'd0, month: 4'd1, day: 5'd1,
                                 hour: 5'd0, min: 6'd0, sec: 6'd0};

  function automatic logic [4:0] rtc_days_in_month(logic [3:0] month, logic [5:0] year);
    case (month)
      4'd2:                    return (year[1:0] == 2'b00) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic logic rtc_cal_valid(cal_t c);
    return (c.sec < 6'd60) && (c.min < 6'd60) && (c.hour < 5'd24) &&
           (c.month >= 4'd1) && (c.month <= 4'd12) && (c.day >= 5'd1) &&
           (c.day <= rtc_days_in_month(c.month, c.year));
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 10,
  parameter int SEL_W = $clog2(PRE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] mask;
  logic [PRE_W:0]   one_sh;
  logic [SEL_W-1:0] sel_c;

  always_comb begin
    sel_c  = (sel_i > SEL_W'(PRE_W)) ? SEL_W'(PRE_W) : sel_i;
    one_sh = (PRE_W+1)'(1) << sel_c;
    mask   = PRE_W'(one_sh - (PRE_W+1)'(1));
    tick_o = en_i && ((div_q & mask) == mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (!en_i)  div_q <= '0;
    else             div_q <= div_q + PRE_W'(1);
  end

  // a divided tick is never followed by another one on the next clock
  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_c != '0 && $stable(sel_i)) |=> !tick_o); // R1
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic [CNT_W-1:0] cur_i,
  output logic [CNT_W-1:0] nxt_o
);
  cal_t c, n;
  logic [4:0] dim;

  always_comb begin
    c   = cal_t'(cur_i);
    dim = rtc_days_in_month(c.month, c.year);
    n   = c;
    if (c.sec >= 6'd59) begin
      n.sec = '0;
      if (c.min >= 6'd59) begin
        n.min = '0;
        if (c.hour >= 5'd23) begin
          n.hour = '0;
          if (c.day >= dim) begin
            n.day = 5'd1;
            if (c.month >= 4'd12) begin
              n.month = 4'd1;
              n.year  = c.year + 6'd1;
            end else begin
              n.month = c.month + 4'd1;
            end
          end else begin
            n.day = c.day + 5'd1;
          end
        end else begin
          n.hour = c.hour + 5'd1;
        end
      end else begin
        n.min = c.min + 6'd1;
      end
    end else begin
      n.sec = c.sec + 6'd1;
    end
    nxt_o = CNT_W'(n);
  end
endmodule

// File: rtl/rtc_multimode.sv
module rtc_multimode
  import rtc_pkg::*;
#(
  parameter  int PRE_W = 10,
  localparam int SEL_W = $clog2(PRE_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [SEL_W-1:0] presc_i,
  input  logic [31:0]      cmp_val_i,
  input  logic             clr_on_match_i,
  input  logic [15:0]      period_i,
  input  logic [31:0]      alarm_i,
  input  logic [5:0]       alarm_en_i,
  input  logic             load_i,
  input  logic [31:0]      load_val_i,
  output logic [31:0]      count_o,
  output logic             cmp_evt_o,
  output logic             ovf_evt_o,
  output logic             alarm_evt_o
);
  rtc_mode_e        mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, cal_nxt, ld_val, pend_val_q, fmask;
  logic             pend_q, tick, mode_chg, do_load;
  logic             cmp_q, ovf_q, alm_q, cmp_d, ovf_d, alm_d;

  rtc_prescaler #(.PRE_W(PRE_W)) presc_i0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .sel_i (presc_i),
    .tick_o(tick)
  );

  rtc_calendar cal_i0 (
    .cur_i(cnt_q),
    .nxt_o(cal_nxt)
  );

  assign mode_chg = (mode_i != mode_q);
  assign do_load  = tick && (load_i || pend_q);
  assign ld_val   = load_i ? load_val_i : pend_val_q;
  assign fmask    = {{6{alarm_en_i[5]}}, {4{alarm_en_i[4]}}, {5{alarm_en_i[3]}},
                     {5{alarm_en_i[2]}}, {6{alarm_en_i[1]}}, {6{alarm_en_i[0]}}};

  always_comb begin
    cnt_d = cnt_q;
    cmp_d = 1'b0;
    ovf_d = 1'b0;
    alm_d = 1'b0;
    if (tick) begin
      case (mode_q)
        MODE_CNT32: begin
          if (do_load) cnt_d = ld_val;
          else if (cnt_q == cmp_val_i) begin
            cmp_d = 1'b1;
            cnt_d = clr_on_match_i ? '0 : cnt_q + 32'd1;
          end else cnt_d = cnt_q + 32'd1;
        end
        MODE_CNT16: begin
          if (do_load) cnt_d = {16'h0, ld_val[15:0]};
          else if (cnt_q[15:0] == period_i || cnt_q[15:0] == 16'hFFFF) begin
            cnt_d = '0;
            ovf_d = 1'b1;
          end else cnt_d = {16'h0, cnt_q[15:0] + 16'd1};
        end
        MODE_CAL: begin
          if (do_load) cnt_d = ld_val;
          else begin
            cnt_d = cal_nxt;
            alm_d = ((cal_nxt ^ alarm_i) & fmask) == '0;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_CNT32;
      cnt_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      cmp_q      <= 1'b0;
      ovf_q      <= 1'b0;
      alm_q      <= 1'b0;
    end else if (mode_chg) begin
      mode_q <= rtc_mode_e'(mode_i);
      cnt_q  <= (rtc_mode_e'(mode_i) == MODE_CAL) ? CNT_W'(CAL_RESET) : '0;
      pend_q <= 1'b0;
      cmp_q  <= 1'b0;
      ovf_q  <= 1'b0;
      alm_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
      ovf_q <= ovf_d;
      alm_q <= alm_d;
      if (do_load) pend_q <= 1'b0;
      else if (load_i) begin
        pend_q     <= 1'b1;
        pend_val_q <= load_val_i;
      end
    end
  end

  assign count_o     = cnt_q;
  assign cmp_evt_o   = cmp_q;
  assign ovf_evt_o   = ovf_q;
  assign alarm_evt_o = alm_q;

  AST_EVT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmp_q, ovf_q, alm_q})); // R10
  AST_EVT_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_q || ovf_q || alm_q) |-> $past(tick)); // R10
  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !mode_chg) |=> $stable(cnt_q)); // R1
  AST_CNT16_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CNT16) |-> (cnt_q[31:16] == 16'h0)); // R4
  AST_CAL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_CAL && tick && !do_load && !mode_chg && rtc_cal_valid(cal_t'(cnt_q)))
    |=> rtc_cal_valid(cal_t'(cnt_q))); // R5
  AST_MODE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg |=> (!cmp_q && !ovf_q && !alm_q)); // R9
  AST_MODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_chg && mode_i != 2'd2) |=> (cnt_q == '0)); // R9
endmodule

// File: tb/rtc_multimode_tb.sv
module rtc_multimode_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [3:0]  presc_i = 4'd0;
  logic [31:0] cmp_val_i = 32'h0;
  logic        clr_on_match_i = 1'b0;
  logic [15:0] period_i = 16'd0;
  logic [31:0] alarm_i = 32'h0;
  logic [5:0]  alarm_en_i = 6'h0;
  logic        load_i = 1'b0;
  logic [31:0] load_val_i = 32'h0;
  logic [31:0] count_o;
  logic        cmp_evt_o, ovf_evt_o, alarm_evt_o;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rtc_multimode dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i), .presc_i(presc_i),
    .cmp_val_i(cmp_val_i), .clr_on_match_i(clr_on_match_i), .period_i(period_i),
    .alarm_i(alarm_i), .alarm_en_i(alarm_en_i), .load_i(load_i), .load_val_i(load_val_i),
    .count_o(count_o), .cmp_evt_o(cmp_evt_o), .ovf_evt_o(ovf_evt_o), .alarm_evt_o(alarm_evt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // reset, settle the mode with the divider stopped, then enable
  task automatic start(input logic [1:0] m, input logic [3:0] p);
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b0; load_i = 1'b0; mode_i = m; presc_i = p;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    en_i = 1'b1;
  endtask

  task automatic do_load(input logic [31:0] v);
    load_i = 1'b1; load_val_i = v;
    @(negedge clk_i);
    load_i = 1'b0;
  endtask

  function automatic logic [31:0] pk(int y, int mo, int d, int h, int mi, int s);
    return {6'(y), 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction

  function automatic int bdim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // reset state
    rst_ni = 1'b0;
    #(CLK_PERIOD * 2);
    chk("R9 reset count", count_o, 32'h0);
    chk("R10 reset events", {29'h0, cmp_evt_o, ovf_evt_o, alarm_evt_o}, 32'h0);

    // R1 divider sweep, exponents above 10 clamp
    cmp_val_i = 32'hFFFF_0000; clr_on_match_i = 1'b0;
    for (int p = 0; p < 16; p++) begin
      int k, pe;
      k  = 2100 + p * 7;
      pe = (p > 10) ? 10 : p;
      start(2'd0, 4'(p));
      step(k);
      chk($sformatf("R1 divide p=%0d", p), count_o, 32'(k >> pe));
    end

    // R1 enable low holds
    start(2'd0, 4'd0);
    step(5);
    en_i = 1'b0;
    step(7);
    chk("R1 hold while disabled", count_o, 32'd5);
    en_i = 1'b1;
    step(3);
    chk("R1 resume", count_o, 32'd8);

    // R3 compare with clear, several compare values
    clr_on_match_i = 1'b1;
    for (int c = 0; c < 6; c++) begin
      cmp_val_i = 32'(c);
      start(2'd0, 4'd0);
      for (int k = 1; k <= 15; k++) begin
        step(1);
        chk($sformatf("R3 clear count c=%0d k=%0d", c, k), count_o, 32'(k % (c + 1)));
        chk($sformatf("R3 clear event c=%0d k=%0d", c, k), {31'h0, cmp_evt_o},
            32'((k % (c + 1)) == 0));
      end
    end

    // R3 compare without clear
    clr_on_match_i = 1'b0; cmp_val_i = 32'd3;
    start(2'd0, 4'd0);
    for (int k = 1; k <= 8; k++) begin
      step(1);
      chk("R2 free count", count_o, 32'(k));
      chk("R3 no-clear event", {31'h0, cmp_evt_o}, 32'(k == 4));
    end

    // R8 deferred load with p=2, R2 wrap
    cmp_val_i = 32'h0001_2345;
    start(2'd0, 4'd2);
    step(1);
    load_i = 1'b1; load_val_i = 32'hA5A5_0000;
    @(negedge clk_i);
    load_i = 1'b0;
    chk("R8 load waits edge2", count_o, 32'h0);
    step(1);
    chk("R8 load waits edge3", count_o, 32'h0);
    step(1);
    chk("R8 load lands on tick", count_o, 32'hA5A5_0000);
    step(4);
    chk("R8 count after load", count_o, 32'hA5A5_0001);

    start(2'd0, 4'd0);
    do_load(32'hFFFF_FFFF);
    chk("R8 immediate load", count_o, 32'hFFFF_FFFF);
    step(1);
    chk("R2 32-bit wrap", count_o, 32'h0);

    // R4 period sweep
    for (int per = 1; per <= 6; per++) begin
      period_i = 16'(per);
      start(2'd1, 4'd0);
      for (int k = 1; k <= 20; k++) begin
        step(1);
        chk($sformatf("R4 count per=%0d k=%0d", per, k), count_o, 32'(k % (per + 1)));
        chk($sformatf("R4 ovf per=%0d k=%0d", per, k), {31'h0, ovf_evt_o},
            32'((k % (per + 1)) == 0));
      end
    end
    period_i = 16'd10;
    start(2'd1, 4'd0);
    do_load(32'h1234_FFFE);
    chk("R4 load masked", count_o, 32'h0000_FFFE);
    step(1);
    chk("R4 above period", count_o, 32'h0000_FFFF);
    step(1);
    chk("R4 16-bit wrap", count_o, 32'h0);
    chk("R4 wrap event", {31'h0, ovf_evt_o}, 32'h1);

    // R5 calendar reset and rollovers
    alarm_en_i = 6'b111111; alarm_i = 32'hFFFF_FFFF;
    start(2'd2, 4'd0);
    chk("R9 calendar reset value", count_o, 32'h0042_0000);
    step(1);
    chk("R5 one second", count_o, pk(0, 1, 1, 0, 0, 1));
    do_load(pk(2, 7, 14, 5, 7, 59));
    step(1);
    chk("R5 minute carry", count_o, pk(2, 7, 14, 5, 8, 0));
    do_load(pk(2, 7, 14, 5, 59, 59));
    step(1);
    chk("R5 hour carry", count_o, pk(2, 7, 14, 6, 0, 0));
    do_load(pk(2, 7, 14, 23, 59, 59));
    step(1);
    chk("R5 day carry", count_o, pk(2, 7, 15, 0, 0, 0));
    for (int y = 0; y < 4; y++) begin
      for (int m = 1; m <= 12; m++) begin
        do_load(pk(y, m, bdim(m, y), 23, 59, 59));
        step(1);
        chk($sformatf("R6 month end y=%0d m=%0d", y, m), count_o,
            (m == 12) ? pk(y + 1, 1, 1, 0, 0, 0) : pk(y, m + 1, 1, 0, 0, 0));
      end
    end
    do_load(pk(63, 12, 31, 23, 59, 59));
    step(1);
    chk("R5 year offset wrap", count_o, pk(0, 1, 1, 0, 0, 0));
    do_load(pk(4, 2, 28, 23, 59, 59));
    step(1);
    chk("R6 leap feb 29", count_o, pk(4, 2, 29, 0, 0, 0));
    do_load(pk(5, 2, 28, 23, 59, 59));
    step(1);
    chk("R6 common feb to march", count_o, pk(5, 3, 1, 0, 0, 0));

    // R7 alarm matching
    alarm_i = pk(0, 0, 9, 11, 0, 0); alarm_en_i = 6'b000111;
    do_load(pk(3, 5, 10, 10, 59, 58));
    chk("R7 no event on load", {31'h0, alarm_evt_o}, 32'h0);
    step(1);
    chk("R7 no match", {31'h0, alarm_evt_o}, 32'h0);
    step(1);
    chk("R7 match", {29'h0, cmp_evt_o, ovf_evt_o, alarm_evt_o}, 32'h1);
    step(1);
    chk("R7 single pulse", {31'h0, alarm_evt_o}, 32'h0);
    alarm_en_i = 6'b001111;
    do_load(pk(3, 5, 10, 10, 59, 59));
    step(1);
    chk("R7 enabled day mismatch", {31'h0, alarm_evt_o}, 32'h0);
    alarm_en_i = 6'b000000;
    step(1);
    chk("R7 all fields masked", {31'h0, alarm_evt_o}, 32'h1);

    // R9 mode changes, R10 hold mode
    cmp_val_i = 32'd5; clr_on_match_i = 1'b0; period_i = 16'd10;
    start(2'd0, 4'd0);
    step(6);
    chk("R3 event before switch", {31'h0, cmp_evt_o}, 32'h1);
    mode_i = 2'd1;
    step(1);
    chk("R9 switch clears count", count_o, 32'h0);
    chk("R9 switch clears events", {29'h0, cmp_evt_o, ovf_evt_o, alarm_evt_o}, 32'h0);
    step(3);
    chk("R9 new mode counts", count_o, 32'd3);
    mode_i = 2'd2;
    step(1);
    chk("R9 switch to calendar", count_o, 32'h0042_0000);
    mode_i = 2'd3;
    step(1);
    chk("R10 hold mode zero", count_o, 32'h0);
    do_load(32'h55);
    step(5);
    chk("R10 hold mode ignores ticks and loads", count_o, 32'h0);

    finish_run();
  end
endmodule